// File: doc/BRIEF.md
# Receive Buffer Descriptor Manager

This block stores received Ethernet frames in memory. The frames are cut into fixed 128-byte buffers. Software prepares a circular list of two-word descriptors. Word 0 of each descriptor holds a word-aligned buffer address, a wrap flag and an ownership flag. Word 1 receives a status word. When a frame starts, the manager reads the current descriptor. If software has released that descriptor, the manager packs the incoming bytes into 32-bit little-endian words and writes them into the buffer. When a buffer fills, the manager hands it back and continues the same frame in the next descriptor.

Only the descriptor that holds the end of a frame gets the complete status: length, end-of-frame and address-match flags. Earlier buffers of the frame carry only the start-of-frame marker and the offset. The first buffer of a frame may begin 0 to 3 bytes past its address. A frame that meets a descriptor still owned by software is discarded and reported with a one-cycle flag. A frame marked bad by the receiver abandons the buffer it is in.

The byte stream is stalled with a ready signal while the manager uses the memory port. The memory port is a request/grant word port. Read data is valid in the grant cycle. Address filtering, the CRC check and bus arbitration happen outside this block.

Top module: `rxbd_mgr`

## Requirements
- R1: After reset, memReq, bufNotAvail and rxReady are low while no byte is offered.
- R2: The first frame after reset reads its descriptor at queueBase. If bit 0 of the read word is 0, the frame bytes go to the buffer whose address is bits 31:2 of that word.
- R3: If bit 0 of a fetched descriptor word is 1, no further writes are made for that frame. bufNotAvail pulses high for exactly one cycle, the remaining bytes are consumed, and the next frame fetches the same descriptor.
- R4: Byte n of a buffer's data goes to byte lane n mod 4 of the word at buffer address + 4*(n div 4), with lane 0 in bits 7:0. A word that is only partly filled is written with byte enables for the filled lanes only, and every write has at least one enable set.
- R5: In the first buffer of a frame, data starts at byte cfgOffset (0 to 3), and that buffer then holds 128 - cfgOffset bytes of the frame.
- R6: Every buffer holds 128 bytes. When a frame continues past a buffer, that buffer's status word is written as bit 14 (start of frame) plus bits 13:12 = offset for the first buffer, and as all zeros for a middle buffer. The frame then continues in the next descriptor at byte 0.
- R7: The status word of the buffer holding the last byte has these fields: bits 11:0 the total frame length in bytes, bit 15 set, bit 14 and bits 13:12 as in R6, and bits 31..28 equal to rxFlags[3..0] (broadcast, multicast hash, unicast hash, specific match) sampled with the last byte. All other bits, including bit 27, are 0.
- R8: A buffer is handed back by writing word 0 as its buffer address, its unchanged wrap bit and bit 0 set, with all byte enables. This write comes after the write of that descriptor's status word.
- R9: After a descriptor whose bit 1 (wrap) is set, the next descriptor is read at queueBase. Otherwise it is read 8 bytes further on.
- R10: A byte offered with rxErr high is not stored. The current buffer gets no status and no ownership write, its partly filled word is discarded, the rest of the frame is consumed, and the next frame reuses the same descriptor.
- R11: memReq stays high with a stable address and direction until memGrant. All memory addresses are word aligned (queueBase must be 8-byte aligned). No byte is accepted while a memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| queueBase | input | 32 | Byte address of the first descriptor, 8-byte aligned |
| cfgOffset | input | 2 | First-buffer byte offset, sampled at frame start |
| rxValid | input | 1 | A byte is offered |
| rxData | input | 8 | Offered byte |
| rxSof | input | 1 | Offered byte is the first of a frame |
| rxEof | input | 1 | Offered byte is the last of a frame |
| rxErr | input | 1 | Frame is bad from this byte on |
| rxFlags | input | 4 | Address-match flags, valid with the last byte |
| rxReady | output | 1 | The offered byte is taken at the next edge |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Word-aligned byte address |
| memWdata | output | 32 | Write data |
| memBe | output | 4 | Byte enables for writes |
| memGnt | input | 1 | Request accepted this cycle |
| memRdata | input | 32 | Read data, valid with memGnt |
| bufNotAvail | output | 1 | One-cycle pulse: descriptor still owned by software |

## Verification
A wrong descriptor pointer shows up at the next frame start: its first memory read goes to the wrong address, and the buffer image and descriptor words in memory differ from the model right after that frame. A wrong byte position or byte-enable register corrupts one word of the buffer image at the next flush, within four accepted bytes. A lost first-buffer or final-status flag appears in the status word written a couple of cycles before ownership. A stuck control state stalls rxReady, and the bench then times out.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

  localparam int LEN_W      = 12;
  localparam int ST_OFF_LO  = 12;
  localparam int ST_SOF     = 14;
  localparam int ST_EOF     = 15;
  localparam int ST_RSV     = 27;
  localparam int ST_FLAG_LO = 28;

  typedef enum logic [2:0] {
    MEM_NONE, MEM_RD_DESC, MEM_WR_DATA, MEM_WR_STAT, MEM_WR_OWN
  } memSel_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_FILL, S_FLUSH, S_STAT, S_OWN, S_DROP
  } ctrlState_e;

  typedef struct packed {
    logic    startFrame;
    logic    loadDesc;
    logic    acceptByte;
    logic    clearWord;
    logic    clearFirst;
    logic    advancePtr;
    logic    finalStat;
    memSel_e memSel;
  } ctrlStrb_t;

endpackage

// File: rtl/rxbd_ctrl.sv
module rxbd_ctrl
  import rxbd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxValid,
  input  logic      rxSof,
  input  logic      rxEof,
  input  logic      rxErr,
  input  logic      memGnt,
  input  logic      descOwned,
  input  logic      laneLast,
  input  logic      bufLast,
  output ctrlStrb_t strb,
  output logic      rxReady,
  output logic      memReq,
  output logic      memWe,
  output logic      bufNotAvail
);

  ctrlState_e state, stateNext;
  logic pendEnd, pendFull;
  logic bnaNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    rxReady   = 1'b0;
    bnaNext   = 1'b0;
    case (state)
      S_IDLE: begin
        // stray bytes outside a frame are drained
        rxReady = rxValid && !rxSof;
        if (rxValid && rxSof) begin
          strb.startFrame = 1'b1;
          stateNext       = S_FETCH;
        end
      end
      S_FETCH: begin
        strb.memSel = MEM_RD_DESC;
        if (memGnt) begin
          if (descOwned) begin
            bnaNext   = 1'b1;
            stateNext = S_DROP;
          end else begin
            strb.loadDesc = 1'b1;
            stateNext     = S_FILL;
          end
        end
      end
      S_FILL: begin
        rxReady = 1'b1;
        if (rxValid) begin
          if (rxErr) begin
            stateNext = rxEof ? S_IDLE : S_DROP;
          end else begin
            strb.acceptByte = 1'b1;
            if (laneLast || rxEof || bufLast) stateNext = S_FLUSH;
          end
        end
      end
      S_FLUSH: begin
        strb.memSel = MEM_WR_DATA;
        if (memGnt) begin
          strb.clearWord = 1'b1;
          stateNext      = (pendEnd || pendFull) ? S_STAT : S_FILL;
        end
      end
      S_STAT: begin
        strb.memSel    = MEM_WR_STAT;
        strb.finalStat = pendEnd;
        if (memGnt) stateNext = S_OWN;
      end
      S_OWN: begin
        strb.memSel = MEM_WR_OWN;
        if (memGnt) begin
          strb.advancePtr = 1'b1;
          if (pendEnd) begin
            stateNext = S_IDLE;
          end else begin
            strb.clearFirst = 1'b1;
            stateNext       = S_FETCH;
          end
        end
      end
      S_DROP: begin
        rxReady = 1'b1;
        if (rxValid && rxEof) stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
    memReq = (strb.memSel != MEM_NONE);
    memWe  = (strb.memSel == MEM_WR_DATA) || (strb.memSel == MEM_WR_STAT) ||
             (strb.memSel == MEM_WR_OWN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      pendEnd     <= 1'b0;
      pendFull    <= 1'b0;
      bufNotAvail <= 1'b0;
    end else begin
      state       <= stateNext;
      bufNotAvail <= bnaNext;
      if (strb.acceptByte) begin
        pendEnd  <= rxEof;
        pendFull <= bufLast;
      end
    end
  end

endmodule

// File: rtl/rxbd_dp.sv
module rxbd_dp
  import rxbd_pkg::*;
#(
  parameter int BUF_BYTES = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrb_t   strb,
  input  logic [31:0] queueBase,
  input  logic [1:0]  cfgOffset,
  input  logic [7:0]  rxData,
  input  logic [3:0]  rxFlags,
  input  logic [31:0] memRdata,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  output logic [3:0]  memBe,
  output logic        descOwned,
  output logic        laneLast,
  output logic        bufLast
);

  localparam int POS_W       = $clog2(BUF_BYTES);
  localparam int IDX_W       = POS_W - 2;
  localparam int DESC_STRIDE = 8;

  logic [31:0]      descPtr, curPtr;
  logic             ptrLoaded;
  logic [29:0]      bufBase;
  logic             wrapBit;
  logic [POS_W-1:0] pos;
  logic [31:0]      wordBuf;
  logic [3:0]       beAcc;
  logic [IDX_W-1:0] wordIdx;
  logic [LEN_W-1:0] frameLen;
  logic             firstBuf;
  logic [1:0]       offLat;
  logic [3:0]       flagLat;
  logic [31:0]      statWord;

  assign curPtr    = ptrLoaded ? descPtr : queueBase;
  assign descOwned = memRdata[0];
  assign laneLast  = (pos[1:0] == 2'd3);
  assign bufLast   = (pos == POS_W'(BUF_BYTES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descPtr   <= '0;
      ptrLoaded <= 1'b0;
      bufBase   <= '0;
      wrapBit   <= 1'b0;
      pos       <= '0;
      wordBuf   <= '0;
      beAcc     <= '0;
      wordIdx   <= '0;
      frameLen  <= '0;
      firstBuf  <= 1'b0;
      offLat    <= '0;
      flagLat   <= '0;
    end else begin
      if (strb.startFrame) begin
        frameLen <= '0;
        firstBuf <= 1'b1;
        offLat   <= cfgOffset;
      end
      if (strb.loadDesc) begin
        bufBase <= memRdata[31:2];
        wrapBit <= memRdata[1];
        pos     <= firstBuf ? POS_W'(offLat) : '0;
        beAcc   <= '0;
      end
      if (strb.acceptByte) begin
        wordBuf[pos[1:0]*8 +: 8] <= rxData;
        beAcc[pos[1:0]]          <= 1'b1;
        wordIdx                  <= pos[POS_W-1:2];
        pos                      <= pos + 1'b1;
        frameLen                 <= frameLen + 1'b1;
        flagLat                  <= rxFlags;
      end
      if (strb.clearWord)  beAcc    <= '0;
      if (strb.clearFirst) firstBuf <= 1'b0;
      if (strb.advancePtr) begin
        descPtr   <= wrapBit ? queueBase : curPtr + DESC_STRIDE;
        ptrLoaded <= 1'b1;
      end
    end
  end

  always_comb begin
    statWord = '0;
    if (firstBuf) begin
      statWord[ST_SOF]                = 1'b1;
      statWord[ST_OFF_LO +: 2]        = offLat;
    end
    if (strb.finalStat) begin
      statWord[ST_EOF]                = 1'b1;
      statWord[LEN_W-1:0]             = frameLen;
      statWord[ST_FLAG_LO +: 4]       = flagLat;
    end
  end

  always_comb begin
    memAddr  = curPtr;
    memWdata = '0;
    memBe    = 4'hF;
    case (strb.memSel)
      MEM_WR_DATA: begin
        memAddr  = {bufBase, 2'b00} + {{(30-IDX_W){1'b0}}, wordIdx, 2'b00};
        memWdata = wordBuf;
        memBe    = beAcc;
      end
      MEM_WR_STAT: begin
        memAddr  = curPtr + 32'd4;
        memWdata = statWord;
      end
      MEM_WR_OWN: memWdata = {bufBase, wrapBit, 1'b1};
      default: ;
    endcase
  end

endmodule

// File: rtl/rxbd_mgr.sv
module rxbd_mgr
  import rxbd_pkg::*;
#(
  parameter int BUF_BYTES = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] queueBase,
  input  logic [1:0]  cfgOffset,
  input  logic        rxValid,
  input  logic [7:0]  rxData,
  input  logic        rxSof,
  input  logic        rxEof,
  input  logic        rxErr,
  input  logic [3:0]  rxFlags,
  output logic        rxReady,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  output logic [3:0]  memBe,
  input  logic        memGnt,
  input  logic [31:0] memRdata,
  output logic        bufNotAvail
);

  ctrlStrb_t strb;
  logic descOwned, laneLast, bufLast;

  rxbd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof), .rxErr(rxErr),
    .memGnt(memGnt), .descOwned(descOwned), .laneLast(laneLast), .bufLast(bufLast),
    .strb(strb), .rxReady(rxReady), .memReq(memReq), .memWe(memWe),
    .bufNotAvail(bufNotAvail)
  );

  rxbd_dp #(.BUF_BYTES(BUF_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .queueBase(queueBase), .cfgOffset(cfgOffset),
    .rxData(rxData), .rxFlags(rxFlags), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe),
    .descOwned(descOwned), .laneLast(laneLast), .bufLast(bufLast)
  );

endmodule

// File: rtl/rxbd_mgr_chk.sv
module rxbd_mgr_chk
  import rxbd_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        rxReady,
  input logic        memReq,
  input logic        memWe,
  input logic [31:0] memAddr,
  input logic [31:0] memWdata,
  input logic [3:0]  memBe,
  input logic        memGnt,
  input logic [31:0] memRdata,
  input logic        bufNotAvail,
  input memSel_e     memSel
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr) && $stable(memWe)); // R11

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[1:0] == 2'b00); // R11

  AST_NO_BYTE_DURING_REQ: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !rxReady); // R11

  AST_OWN_BIT_SET: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memSel == MEM_WR_OWN |-> memWe && memWdata[0] && memBe == 4'hF); // R8

  AST_BNA_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    bufNotAvail |-> $past(memReq && !memWe && memGnt && memRdata[0])); // R3

  AST_BNA_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    bufNotAvail |=> !bufNotAvail); // R3

  AST_WRITE_HAS_BE: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> memBe != 4'h0); // R4

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memSel == MEM_WR_STAT |-> !memWdata[ST_RSV]); // R7

endmodule

bind rxbd_mgr rxbd_mgr_chk chk_i (
  .clk(clk), .rstN(rstN), .rxReady(rxReady), .memReq(memReq), .memWe(memWe),
  .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe), .memGnt(memGnt),
  .memRdata(memRdata), .bufNotAvail(bufNotAvail), .memSel(strb.memSel)
);

// File: tb/rxbd_mgr_tb.sv
`timescale 1ns/1ps
module rxbd_mgr_tb_top;

  localparam int BASE    = 32'h100;
  localparam int NDESC   = 4;
  localparam int BUFBASE = 32'h1000;
  localparam int BUFSZ   = 128;
  localparam int MEMW    = 4096;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] queueBase = BASE;
  logic [1:0]  cfgOffset = 2'd0;
  logic        rxValid = 1'b0, rxSof = 1'b0, rxEof = 1'b0, rxErr = 1'b0;
  logic [7:0]  rxData = '0;
  logic [3:0]  rxFlags = '0;
  logic        rxReady, memReq, memWe, bufNotAvail;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [3:0]  memBe;
  logic        memGnt = 1'b0;

  logic [31:0] mem    [0:MEMW-1];
  logic [31:0] expMem [0:MEMW-1];
  logic [7:0]  frameBytes [0:511];
  bit          statSeen [0:NDESC-1];
  int          modelPtr = BASE;
  int          expBna = 0, bnaSeen = 0;
  int          errors = 0, checks = 0;

  always #2 clk = ~clk;

  rxbd_mgr dut_i (
    .clk(clk), .rstN(rstN), .queueBase(queueBase), .cfgOffset(cfgOffset),
    .rxValid(rxValid), .rxData(rxData), .rxSof(rxSof), .rxEof(rxEof), .rxErr(rxErr),
    .rxFlags(rxFlags), .rxReady(rxReady), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe), .memGnt(memGnt),
    .memRdata(memRdata), .bufNotAvail(bufNotAvail)
  );

  assign memRdata = mem[memAddr[13:2]];

  // R11 stress: the grant is withheld at random
  always @(negedge clk) memGnt <= ($urandom % 4) != 0;

  always @(negedge clk) if (rstN && bufNotAvail) bnaSeen++;

  // memory model plus R8 ordering monitor
  always @(posedge clk) begin
    if (rstN && memReq && memGnt && memWe) begin
      for (int b = 0; b < 4; b++)
        if (memBe[b]) mem[memAddr[13:2]][b*8 +: 8] <= memWdata[b*8 +: 8];
      if (memAddr >= BASE && memAddr < BASE + 8*NDESC) begin
        if (memAddr[2]) statSeen[(memAddr - BASE) >> 3] = 1'b1;
        else begin
          checks++;
          if (!statSeen[(memAddr - BASE) >> 3]) begin
            errors++;
            $display("FAIL R8 ownership write at %h before status: got 0 expected 1", memAddr);
          end
          statSeen[(memAddr - BASE) >> 3] = 1'b0;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] stWord(bit fin, bit first, int off, int len, logic [3:0] flg);
    logic [31:0] st = '0;
    if (first) begin st[14] = 1'b1; st[13:12] = off[1:0]; end
    if (fin) begin st[15] = 1'b1; st[11:0] = len[11:0]; st[31:28] = flg; end
    return st;
  endfunction

  task automatic modelFrame(input int len, input int off, input logic [3:0] flg, input int errIdx);
    int ptr, pos, idx, base, lane;
    bit first;
    logic [31:0] d0, pw;
    logic [3:0] pbe;
    first = 1; pos = off; idx = 0;
    forever begin
      ptr = modelPtr;
      d0 = expMem[ptr >> 2];
      if (d0[0]) begin expBna++; return; end
      base = {d0[31:2], 2'b00};
      pw = '0; pbe = '0;
      while (pos < BUFSZ && idx < len) begin
        if (idx == errIdx) return;
        lane = pos % 4;
        pw[lane*8 +: 8] = frameBytes[idx];
        pbe[lane] = 1'b1;
        if (lane == 3 || idx == len - 1 || pos == BUFSZ - 1) begin
          for (int b = 0; b < 4; b++)
            if (pbe[b]) expMem[(base + (pos & ~3)) >> 2][b*8 +: 8] = pw[b*8 +: 8];
          pbe = '0;
        end
        pos++; idx++;
      end
      expMem[(ptr + 4) >> 2] = stWord(idx == len, first, off, len, flg);
      expMem[ptr >> 2] = d0 | 32'd1;
      modelPtr = d0[1] ? BASE : ptr + 8;
      if (idx == len) return;
      first = 0; pos = 0;
    end
  endtask

  task automatic sendFrame(input int len, input int off, input logic [3:0] flg, input int errIdx);
    int quiet;
    for (int i = 0; i < len; i++) frameBytes[i] = 8'($urandom);
    modelFrame(len, off, flg, errIdx);
    @(negedge clk);
    cfgOffset = off[1:0];
    for (int i = 0; i < len; i++) begin
      rxValid = 1'b1; rxData = frameBytes[i]; rxSof = (i == 0);
      rxEof = (i == len - 1); rxErr = (i == errIdx); rxFlags = flg;
      #1;
      while (!rxReady) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    rxValid = 1'b0; rxSof = 1'b0; rxEof = 1'b0; rxErr = 1'b0;
    quiet = 0;
    while (quiet < 12) begin @(negedge clk); quiet = memReq ? 0 : quiet + 1; end
  endtask

  task automatic checkImage(input string req);
    for (int d = 0; d < NDESC; d++) begin
      chk(req, $sformatf("desc%0d word0", d), mem[(BASE + 8*d) >> 2], expMem[(BASE + 8*d) >> 2]);
      chk(req, $sformatf("desc%0d status", d), mem[(BASE + 8*d + 4) >> 2], expMem[(BASE + 8*d + 4) >> 2]);
    end
    for (int w = 0; w < NDESC*BUFSZ/4; w++)
      chk(req, $sformatf("buffer word %0d", w), mem[(BUFBASE >> 2) + w], expMem[(BUFBASE >> 2) + w]);
    chk(req, "bufNotAvail pulses", bnaSeen, expBna);
  endtask

  task automatic setOwn(input bit owned);
    for (int d = 0; d < NDESC; d++) begin
      mem[(BASE + 8*d) >> 2][0] = owned;
      expMem[(BASE + 8*d) >> 2][0] = owned;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int w = 0; w < MEMW; w++) begin mem[w] = 32'hA5A5_A5A5; expMem[w] = 32'hA5A5_A5A5; end
    for (int d = 0; d < NDESC; d++) begin
      mem[(BASE + 8*d) >> 2] = BUFBASE + BUFSZ*d + ((d == NDESC - 1) ? 2 : 0);
      expMem[(BASE + 8*d) >> 2] = mem[(BASE + 8*d) >> 2];
      statSeen[d] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "memReq after reset", 32'(memReq), 0);
    chk("R1", "rxReady after reset", 32'(rxReady), 0);
    chk("R1", "bufNotAvail after reset", 32'(bufNotAvail), 0);

    sendFrame(5, 0, 4'b0001, -1);   checkImage("R2");
    setOwn(0); sendFrame(128, 0, 4'b1000, -1); checkImage("R6");
    setOwn(0); sendFrame(126, 2, 4'b0100, -1); checkImage("R5");
    setOwn(0); sendFrame(300, 3, 4'b0010, -1); checkImage("R6");  // crosses wrap: R9
    setOwn(0); sendFrame(7, 1, 4'b1010, -1);   checkImage("R7");
    setOwn(0); sendFrame(40, 0, 4'b0000, 10);  checkImage("R10");
    sendFrame(9, 0, 4'b0001, -1);              checkImage("R10");
    setOwn(1); sendFrame(20, 0, 4'b0001, -1);  checkImage("R3");
    setOwn(0); sendFrame(6, 2, 4'b0100, -1);   checkImage("R3");
    setOwn(0); sendFrame(129, 1, 4'b0011, -1); checkImage("R9");

    for (int n = 0; n < 40; n++) begin
      if (($urandom % 10) < 7) setOwn(0);
      sendFrame(1 + $urandom % 260, $urandom % 4, 4'($urandom),
                (($urandom % 10) == 0) ? 1 + $urandom % 8 : -1);
      checkImage("R4");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule